// File: doc/BRIEF.md
# Masked Vector Scatter Sequencer

This block takes a single vector scatter request and turns it into a stream of single-element memory stores. A request holds a data vector, an index vector, a per-element write mask, a vector-length code, the index and data element widths (32 or 64 bits), a mask-register selector and a zeroing flag. Elements are visited in ascending order. Elements whose mask bit is clear are skipped at no cost in cycles. Each active element is sent as one store on a valid/ready write port. The store address comes from an external address generator, which receives the element's sign-extended index.

Each store is followed by a one-cycle-late ok/fault response. An ok response clears that element's mask bit. A fault response stops the walk at the faulting element. The mask is then left partly cleared, so that the same request can be reissued later and resume at the element that faulted. A request with an illegal encoding issues no stores. A request with no active mask bits finishes at once.

Top module: `vsc_seq`

## Requirements
- R1: The element count is 4, 8 or 16 for vector-length codes 0, 1 and 2 when both the index and the data are 32 bits wide. It is 2, 4 or 8 for the same codes when either of them is 64 bits wide. Mask bits at or above the element count issue no store.
- R2: Element j is stored only when mask bit j is set. Its data is bits [64j+63:64j] of the data vector in 64-bit data mode, and zero-extended bits [32j+31:32j] in 32-bit data mode. `wr_size8` is 1 for 8-byte stores and 0 for 4-byte stores.
- R3: Stores are issued in strictly ascending element order, starting from element 0. `agen_index` carries the element's index: bits [64j+63:64j] of the index vector in 64-bit index mode, or sign-extended bits [32j+31:32j] in 32-bit index mode. `wr_addr` equals `agen_addr`.
- R4: An ok response clears the mask bit of the stored element. No mask bit is ever set while the block is busy.
- R5: When a request ends without a fault, `done` pulses for one cycle, `fault` is 0 and the whole mask is zero, including the bits above the element count.
- R6: A fault response ends the request. `done` pulses, `fault` is 1, `fault_elem` holds the faulting element, and the mask keeps the bits of the faulting and all later elements. Only the bits of earlier stored elements are cleared.
- R7: A request with mask selector 0, with the zeroing flag set, or with vector-length code 3 is illegal. It raises `illegal` and `done` on the next cycle, issues no store and leaves the mask equal to the request mask.
- R8: A legal request with no mask bit set below the element count raises `done` on the cycle after `start`, issues no store, never raises `busy`, and clears the whole mask.
- R9: A store whose `wr_valid` is high and is not accepted keeps `wr_valid`, `wr_addr`, `wr_data` and `agen_elem` unchanged in the next cycle.
- R10: After reset the block is idle, with `busy`, `done`, `fault`, `illegal` and `wr_valid` at 0 and the mask at zero.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| req_data | input | VEC_BITS | Data vector |
| req_index | input | VEC_BITS | Index vector |
| req_mask | input | VEC_BITS/32 | Per-element write mask |
| req_vlen | input | 2 | Vector-length code (0,1,2; 3 illegal) |
| req_idx64 | input | 1 | Index elements are 64 bits |
| req_dat64 | input | 1 | Data elements are 64 bits |
| req_ksel | input | 3 | Mask register selector (0 illegal) |
| req_zero | input | 1 | Zeroing flag (illegal when set) |
| agen_index | output | 64 | Sign-extended index of current element |
| agen_elem | output | $clog2(VEC_BITS/32) | Number of current element |
| agen_addr | input | ADDR_W | Address returned by the generator |
| wr_valid | output | 1 | Store request valid |
| wr_ready | input | 1 | Store request accepted |
| wr_addr | output | ADDR_W | Store address |
| wr_data | output | 64 | Store data |
| wr_size8 | output | 1 | 1: 8-byte store, 0: 4-byte store |
| rsp_valid | input | 1 | Store response valid |
| rsp_fault | input | 1 | Store response is a fault |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last request ended on a fault |
| fault_elem | output | $clog2(VEC_BITS/32) | Faulting element |
| illegal | output | 1 | Last request was rejected |
| mask_out | output | VEC_BITS/32 | Current mask |

## Verification
An illegal request, or a request with no active mask bits, must show `done` at the first sample after the clock edge that takes `start`. The bench checks exactly that sample. Each store is compared with the model at the sample where `wr_valid` and `wr_ready` are both high, which is just before the edge that accepts it. The response is driven so that the design sees it on the following edge. Mask, fault flag, fault element and store count are read at the sample where `done` is high, and the next sample confirms that `done` has fallen.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } vsc_state_e;

    localparam logic [1:0] VLEN_BAD = 2'd3;
endpackage

// File: rtl/vsc_first_set.sv
module vsc_first_set #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vsc_lane_mux.sv
module vsc_lane_mux #(
    parameter int VEC_BITS = 512,
    localparam int NE = VEC_BITS / 32,
    localparam int NQ = VEC_BITS / 64,
    localparam int EW = $clog2(NE)
) (
    input  logic [VEC_BITS-1:0] data_vec,
    input  logic [VEC_BITS-1:0] index_vec,
    input  logic                idx64,
    input  logic                dat64,
    input  logic [EW-1:0]       elem,
    output logic [63:0]         elem_data,
    output logic [63:0]         elem_index
);
    logic [31:0] d_dw [NE];
    logic [31:0] i_dw [NE];
    logic [63:0] d_qw [NQ];
    logic [63:0] i_qw [NQ];

    for (genvar g = 0; g < NE; g++) begin : g_dw
        assign d_dw[g] = data_vec[g*32 +: 32];
        assign i_dw[g] = index_vec[g*32 +: 32];
    end
    for (genvar g = 0; g < NQ; g++) begin : g_qw
        assign d_qw[g] = data_vec[g*64 +: 64];
        assign i_qw[g] = index_vec[g*64 +: 64];
    end

    logic [31:0] d_lo, i_lo;
    always_comb begin
        d_lo       = d_dw[elem];
        i_lo       = i_dw[elem];
        elem_data  = dat64 ? d_qw[elem[EW-2:0]] : {32'b0, d_lo};
        elem_index = idx64 ? i_qw[elem[EW-2:0]] : {{32{i_lo[31]}}, i_lo};
    end
endmodule

// File: rtl/vsc_seq.sv
module vsc_seq #(
    parameter int VEC_BITS = 512,
    parameter int ADDR_W   = 32,
    localparam int NE = VEC_BITS / 32,
    localparam int EW = $clog2(NE),
    localparam int CW = EW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VEC_BITS-1:0] req_data,
    input  logic [VEC_BITS-1:0] req_index,
    input  logic [NE-1:0]       req_mask,
    input  logic [1:0]          req_vlen,
    input  logic                req_idx64,
    input  logic                req_dat64,
    input  logic [2:0]          req_ksel,
    input  logic                req_zero,
    output logic [63:0]         agen_index,
    output logic [EW-1:0]       agen_elem,
    input  logic [ADDR_W-1:0]   agen_addr,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [63:0]         wr_data,
    output logic                wr_size8,
    input  logic                rsp_valid,
    input  logic                rsp_fault,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [EW-1:0]       fault_elem,
    output logic                illegal,
    output logic [NE-1:0]       mask_out
);
    import vsc_pkg::*;

    typedef struct packed {
        vsc_state_e          st;
        logic [NE-1:0]       mask;
        logic [VEC_BITS-1:0] data;
        logic [VEC_BITS-1:0] index;
        logic [CW-1:0]       cnt;
        logic                idx64;
        logic                dat64;
        logic [EW-1:0]       cur;
        logic                done;
        logic                fault;
        logic [EW-1:0]       fe;
        logic                illegal;
    } seq_state_t;

    seq_state_t s_d, s_q;

    function automatic logic [NE-1:0] below(input logic [CW-1:0] c);
        logic [NE-1:0] l;
        for (int j = 0; j < NE; j++) l[j] = (j < int'(c));
        return l;
    endfunction

    logic [CW-1:0] req_cnt;
    logic          req_bad;
    logic [NE-1:0] live_mask;
    logic          any_live;
    logic [EW-1:0] next_elem;
    logic [63:0]   sel_data, sel_index;

    assign req_cnt = (req_idx64 | req_dat64) ? (CW'(2) << req_vlen) : (CW'(4) << req_vlen);
    assign req_bad = (req_ksel == 3'd0) | req_zero | (req_vlen == VLEN_BAD);
    assign live_mask = s_q.mask & below(s_q.cnt);

    vsc_first_set #(.W(NE)) u_first (
        .vec   (live_mask),
        .found (any_live),
        .idx   (next_elem)
    );

    vsc_lane_mux #(.VEC_BITS(VEC_BITS)) u_lane (
        .data_vec   (s_q.data),
        .index_vec  (s_q.index),
        .idx64      (s_q.idx64),
        .dat64      (s_q.dat64),
        .elem       (next_elem),
        .elem_data  (sel_data),
        .elem_index (sel_index)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.fault   = 1'b0;
                    s_d.illegal = 1'b0;
                    s_d.fe      = '0;
                    if (req_bad) begin
                        s_d.illegal = 1'b1;
                        s_d.done    = 1'b1;
                        s_d.mask    = req_mask;
                    end else begin
                        s_d.data  = req_data;
                        s_d.index = req_index;
                        s_d.cnt   = req_cnt;
                        s_d.idx64 = req_idx64;
                        s_d.dat64 = req_dat64;
                        if ((req_mask & below(req_cnt)) == '0) begin
                            s_d.mask = '0;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.mask = req_mask;
                            s_d.st   = ST_ISSUE;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                if (!any_live) begin
                    s_d.mask = '0;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else if (wr_ready) begin
                    s_d.cur = next_elem;
                    s_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_fault) begin
                        s_d.fault = 1'b1;
                        s_d.fe    = s_q.cur;
                        s_d.done  = 1'b1;
                        s_d.st    = ST_IDLE;
                    end else begin
                        s_d.mask[s_q.cur] = 1'b0;
                        s_d.st            = ST_ISSUE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign agen_index = sel_index;
    assign agen_elem  = next_elem;
    assign wr_valid   = (s_q.st == ST_ISSUE) && any_live;
    assign wr_addr    = agen_addr;
    assign wr_data    = sel_data;
    assign wr_size8   = s_q.dat64;
    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;
    assign fault      = s_q.fault;
    assign fault_elem = s_q.fe;
    assign illegal    = s_q.illegal;
    assign mask_out   = s_q.mask;
endmodule

// File: rtl/vsc_seq_chk.sv
module vsc_seq_chk #(
    parameter int NE     = 16,
    parameter int ADDR_W = 32,
    localparam int EW = $clog2(NE)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [63:0]       wr_data,
    input logic [EW-1:0]     agen_elem,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic              illegal,
    input logic [NE-1:0]     mask_out
);
    logic          seen_q;
    logic [EW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (done) begin
            seen_q <= 1'b0;
        end else if (wr_valid && wr_ready) begin
            seen_q <= 1'b1;
            last_q <= agen_elem;
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(agen_elem)); // R9
    AST_MASK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((mask_out & ~$past(mask_out)) == '0)); // R4
    AST_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault && !illegal |-> mask_out == '0); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_valid && !busy); // R7
    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid && !busy); // R6
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && seen_q |-> agen_elem > last_q); // R3
endmodule

bind vsc_seq vsc_seq_chk #(.NE(NE), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .agen_elem (agen_elem),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .illegal   (illegal),
    .mask_out  (mask_out)
);

// File: tb/vsc_seq_tb.sv
module vsc_seq_tb_top;
    localparam int VB = 512;
    localparam int NE = VB / 32;
    localparam int EW = $clog2(NE);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [VB-1:0]   req_data = '0, req_index = '0;
    logic [NE-1:0]   req_mask = '0;
    logic [1:0]      req_vlen = '0;
    logic            req_idx64 = 1'b0, req_dat64 = 1'b0, req_zero = 1'b0;
    logic [2:0]      req_ksel = 3'd1;
    logic [63:0]     agen_index;
    logic [EW-1:0]   agen_elem;
    logic [31:0]     agen_addr;
    logic            wr_valid, wr_size8;
    logic            wr_ready = 1'b0;
    logic [31:0]     wr_addr;
    logic [63:0]     wr_data;
    logic            rsp_valid = 1'b0, rsp_fault = 1'b0;
    logic            busy, done, fault, illegal;
    logic [EW-1:0]   fault_elem;
    logic [NE-1:0]   mask_out;

    assign agen_addr = 32'h1000 + agen_index[31:0] * 32'd4;

    vsc_seq #(.VEC_BITS(VB), .ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_data(req_data),
        .req_index(req_index), .req_mask(req_mask), .req_vlen(req_vlen),
        .req_idx64(req_idx64), .req_dat64(req_dat64), .req_ksel(req_ksel),
        .req_zero(req_zero), .agen_index(agen_index), .agen_elem(agen_elem),
        .agen_addr(agen_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size8(wr_size8),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .busy(busy), .done(done),
        .fault(fault), .fault_elem(fault_elem), .illegal(illegal), .mask_out(mask_out)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] mask;
        logic [1:0]  vlen;
        logic        i64;
        logic        d64;
        logic [2:0]  ksel;
        logic        zero;
        logic [4:0]  ford;
        logic [4:0]  exp_n;
        logic [15:0] exp_mask;
        logic        exp_flt;
        logic [3:0]  exp_fe;
        logic        exp_ill;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'hFFFF, 2'd2, 1'b0, 1'b0, 3'd1, 1'b0, 5'd31, 5'd16, 16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'hFFFF, 2'd0, 1'b0, 1'b0, 3'd2, 1'b0, 5'd31, 5'd4,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'h00A5, 2'd1, 1'b0, 1'b0, 3'd1, 1'b0, 5'd31, 5'd4,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'hF0F0, 2'd0, 1'b1, 1'b0, 3'd1, 1'b0, 5'd31, 5'd0,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'h00FF, 2'd2, 1'b0, 1'b1, 3'd3, 1'b0, 5'd31, 5'd8,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'h0013, 2'd0, 1'b1, 1'b1, 3'd1, 1'b0, 5'd31, 5'd2,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'h00FF, 2'd2, 1'b0, 1'b0, 3'd1, 1'b0, 5'd3,  5'd4,  16'h00F8, 1'b1, 4'd3, 1'b0},
        '{16'h8001, 2'd2, 1'b1, 1'b0, 3'd1, 1'b0, 5'd31, 5'd1,  16'h0000, 1'b0, 4'd0, 1'b0},
        '{16'hFFFF, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 5'd31, 5'd0,  16'hFFFF, 1'b0, 4'd0, 1'b1},
        '{16'h1234, 2'd1, 1'b0, 1'b0, 3'd4, 1'b1, 5'd31, 5'd0,  16'h1234, 1'b0, 4'd0, 1'b1},
        '{16'h0F0F, 2'd3, 1'b0, 1'b0, 3'd1, 1'b0, 5'd31, 5'd0,  16'h0F0F, 1'b0, 4'd0, 1'b1},
        '{16'h0006, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0, 5'd0,  5'd1,  16'h0006, 1'b1, 4'd1, 1'b0}
    };

    // expected stores, built from the requirements
    logic [31:0] e_addr [16];
    logic [63:0] e_data [16];
    logic [63:0] e_idx  [16];
    logic        e_sz8;
    int          e_n = 0;
    int          wn = 0;
    int          fault_ord = 31;
    bit          hs_seen = 1'b0, hs_fault = 1'b0;
    int          cyc = 0;

    function automatic logic [VB-1:0] mk_data();
        logic [VB-1:0] v;
        for (int g = 0; g < NE; g++) v[g*32 +: 32] = 32'hA000_0000 | (g << 8) | g;
        return v;
    endfunction

    function automatic logic [VB-1:0] mk_index(input bit i64);
        logic [VB-1:0] v;
        if (i64) for (int g = 0; g < NE/2; g++) v[g*64 +: 64] = 64'(g * 5 - 2);
        else     for (int g = 0; g < NE; g++)   v[g*32 +: 32] = 32'(g * 3 - 4);
        return v;
    endfunction

    task automatic build_exp(input logic [15:0] m, input logic [1:0] vl, input bit i64, input bit d64);
        logic [VB-1:0] dv, iv;
        int cnt;
        dv = mk_data();
        iv = mk_index(i64);
        cnt = (i64 || d64) ? (2 << vl) : (4 << vl);   // R1
        e_n = 0;
        e_sz8 = d64;
        for (int j = 0; j < cnt; j++) begin
            if (m[j]) begin
                e_idx[e_n]  = i64 ? iv[j*64 +: 64] : {{32{iv[j*32+31]}}, iv[j*32 +: 32]};
                e_data[e_n] = d64 ? dv[j*64 +: 64] : {32'b0, dv[j*32 +: 32]};
                e_addr[e_n] = 32'h1000 + e_idx[e_n][31:0] * 32'd4;
                e_n++;
            end
        end
    endtask

    // store monitor: sample between edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        hs_seen  = wr_valid && wr_ready;
        hs_fault = hs_seen && (wn == fault_ord);
        if (hs_seen) begin
            if (wn < e_n) begin
                chk(wr_addr == e_addr[wn], "R3 store address", longint'(wr_addr), longint'(e_addr[wn]));
                chk(agen_index == e_idx[wn], "R3 index to generator", longint'(agen_index), longint'(e_idx[wn]));
                chk(wr_data == e_data[wn], "R2 store data", longint'(wr_data), longint'(e_data[wn]));
                chk(wr_size8 == e_sz8, "R2 store size", longint'(wr_size8), longint'(e_sz8));
            end else begin
                chk(1'b0, "R2 unexpected store", longint'(wn), longint'(e_n));
            end
            wn++;
        end
    end

    // memory side: ready pattern and one-cycle response
    always @(posedge clk) begin
        #1;
        rsp_valid = hs_seen;
        rsp_fault = hs_fault;
        wr_ready  = (cyc % 3) != 2;
    end

    task automatic issue(input vec_t v);
        @(posedge clk); #1;
        req_data  = mk_data();
        req_index = mk_index(v.i64);
        req_mask  = v.mask;
        req_vlen  = v.vlen;
        req_idx64 = v.i64;
        req_dat64 = v.d64;
        req_ksel  = v.ksel;
        req_zero  = v.zero;
        start     = 1'b1;
        @(posedge clk); #1;
        start     = 1'b0;
    endtask

    task automatic wait_done(output int waited);
        waited = 0;
        @(negedge clk);
        while (!done && waited < 500) begin
            waited++;
            @(negedge clk);
        end
        chk(done, "R5 done reached", longint'(done), 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int waited;
        vec_t v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !fault && !illegal, "R10 reset flags", longint'({busy, done, fault, illegal}), 0);
        chk(!wr_valid, "R10 reset wr_valid", longint'(wr_valid), 0);
        chk(mask_out == '0, "R10 reset mask", longint'(mask_out), 0);

        for (int k = 0; k < 12; k++) begin
            v = VECS[k];
            build_exp(v.mask, v.vlen, v.i64, v.d64);
            if (v.exp_ill) e_n = 0;
            wn = 0;
            fault_ord = int'(v.ford);
            issue(v);
            wait_done(waited);
            chk(wn == int'(v.exp_n), "R1 store count", longint'(wn), longint'(v.exp_n));
            chk(mask_out == v.exp_mask, "R4 final mask", longint'(mask_out), longint'(v.exp_mask));
            chk(fault == v.exp_flt, "R6 fault flag", longint'(fault), longint'(v.exp_flt));
            if (v.exp_flt)
                chk(fault_elem == v.exp_fe, "R6 fault element", longint'(fault_elem), longint'(v.exp_fe));
            chk(illegal == v.exp_ill, "R7 illegal flag", longint'(illegal), longint'(v.exp_ill));
            if (v.exp_n == 0)
                chk(waited == 0, "R8 R7 done on next cycle", longint'(waited), 0);
            @(negedge clk);
            chk(!done, "R5 done is one pulse", longint'(done), 0);
        end

        // R8: empty active mask never raises busy
        v = VECS[3];
        build_exp(v.mask, v.vlen, v.i64, v.d64);
        wn = 0;
        fault_ord = 31;
        issue(v);
        chk(!busy && done, "R8 no busy on empty mask", longint'({busy, done}), 1);

        // R11: a second start while busy is ignored
        v = VECS[0];
        build_exp(v.mask, v.vlen, v.i64, v.d64);
        wn = 0;
        fault_ord = 31;
        issue(v);
        repeat (4) @(posedge clk);
        #1;
        req_ksel = 3'd0;
        req_mask = 16'h0001;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done(waited);
        chk(!illegal, "R11 busy start ignored (illegal)", longint'(illegal), 0);
        chk(wn == 16, "R11 busy start ignored (stores)", longint'(wn), 16);
        chk(mask_out == '0, "R11 busy start ignored (mask)", longint'(mask_out), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule